// File: doc/BRIEF.md
# Package Thermal Event Controller

This block gathers the temperature state of a processor package and turns it into protective actions. It reads an 8-bit digital temperature from every core and a catastrophic-trip flag from every core sensor and from the one uncore sensor. When any trip flag rises, it pulls an active-low trip output and the power-good line of the clock generators low at once, through plain gates with no clocked stage. Power-good then stays low until the next reset.

On the clocked side, an exact match between any core reading and the fused trip temperature drives an active-low hot output. The same match raises a request to lower the core voltage/frequency point. The platform can force throttling with an active-low input. That input is synchronized, and it requests the lowest supported frequency ratio. While either source asks for throttling, the block gates core clocks with an enable pulse whose duty cycle is set per 16-cycle window.

A small state machine tracks the throttle sources. Its states are `TS_RUN` (no source), `TS_HOT` (hot match only), `TS_FORCED` (platform force only) and `TS_BOTH` (both). Each cycle the machine moves directly to the state named by the current pair {force, hot}: 00 goes to `TS_RUN`, 01 to `TS_HOT`, 10 to `TS_FORCED` and 11 to `TS_BOTH`. Every state can reach every other state in one step.

Top module: `pkg_therm_ctrl`

## Requirements
- R1: `trip_n` is low whenever any bit of `trip_flag` is high, and high otherwise, with no clock edge needed. Bits 0..NCORE-1 are the core sensors and bit NCORE is the uncore sensor.
- R2: `pll_pwrgood` goes low combinationally, in the same instant, when any `trip_flag` bit rises.
- R3: Once `pll_pwrgood` has dropped because of a trip, it stays low after every flag clears, until `rst_n` is driven low. It returns high on the first clock edge after `rst_n` is released, provided no flag is set.
- R4: `hot_n` goes low on the first clock edge after any core reading (core i at `core_temp[8i+7:8i]`) equals `fuse_trip` exactly. A reading one above or one below `fuse_trip` does not assert it.
- R5: `hot_n` stays low for as long as some core still matches. It returns high on the first edge after no core matches.
- R6: `tm_req` (the request to lower the voltage/frequency point) follows `hot_n` one edge later. It rises or falls on the second edge after the match starts or ends.
- R7: `force_thr_n` passes through two synchronizing flops. `min_ratio_req` rises on the third edge after a low level is first sampled, and falls on the third edge after a high level is first sampled.
- R8: `thr_req` is high when `tm_req` or `min_ratio_req` is high. `src_status[0]` shows the hot source and `src_status[1]` shows the forced source.
- R9: `clkmod_en` is high while `thr_req` is low. While `thr_req` is high, time is split into 16-cycle windows, the first window starting in the cycle `thr_req` rises. `clkmod_en` is high in the first `duty_cfg` cycles of each window and low in the rest.
- R10: A `duty_cfg` of 0 is treated as 8, which gives a 50 percent duty cycle.
- R11: While `rst_n` is low, the outputs sit at these values: `hot_n` high, `tm_req`, `min_ratio_req`, `thr_req` and `src_status` zero, `clkmod_en` high, `pll_pwrgood` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| core_temp | input | NCORE*TW | Packed core readings, core i at bits [TW*i+TW-1:TW*i] |
| fuse_trip | input | TW | Fused thermal-monitor trip temperature |
| trip_flag | input | NCORE+1 | Catastrophic trip flags, bit NCORE is the uncore sensor |
| force_thr_n | input | 1 | Asynchronous active-low platform force-throttle |
| duty_cfg | input | WIN_BITS | Enabled cycles per 16-cycle window, 0 selects half |
| trip_n | output | 1 | Active-low catastrophic trip |
| pll_pwrgood | output | 1 | Power-good to the clock generators |
| hot_n | output | 1 | Active-low hot indication |
| tm_req | output | 1 | Request to lower the voltage/frequency point |
| min_ratio_req | output | 1 | Request for the lowest supported ratio |
| thr_req | output | 1 | Any throttle request active |
| clkmod_en | output | 1 | Core clock modulation enable pulse |
| src_status | output | 2 | Active throttle sources {forced, hot} |

## Verification
The bench probes the trip path between clock edges. A design that registered the OR, or that released power-good as soon as the flags cleared, would show a late `trip_n` or a premature `pll_pwrgood`. Off-by-one readings around the fused value catch a threshold comparison used in place of an exact match. Counting edges after a forced-throttle pulse exposes a missing or extra synchronizer stage. Counting enabled cycles in a window with `duty_cfg` at 0 catches modulation that stops the clock entirely or misplaces the window start.

// File: rtl/therm_pkg.sv
package therm_pkg;

    // Throttle state machine: bit 1 = forced source, bit 0 = hot source
    typedef enum logic [1:0] {
        TS_RUN    = 2'b00,
        TS_HOT    = 2'b01,
        TS_FORCED = 2'b10,
        TS_BOTH   = 2'b11
    } thr_state_t;

    localparam int DEF_NCORE    = 10;
    localparam int DEF_TW       = 8;
    localparam int DEF_WIN_BITS = 4;

endpackage

// File: rtl/trip_guard.sv
module trip_guard #(
    parameter int NSENS = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSENS-1:0] trip_flag,
    output logic             trip_n,
    output logic             pll_pwrgood
);
    logic trip_any;
    logic tripped_q;
    logic pg_arm_q;

    // Purely combinational OR: no clocked stage between flags and pins
    assign trip_any = |trip_flag;
    assign trip_n   = ~trip_any;

    // Sticky record of a trip; set asynchronously, cleared only under reset
    always_ff @(posedge clk or posedge trip_any) begin
        if (trip_any)
            tripped_q <= 1'b1;
        else if (!rst_n)
            tripped_q <= 1'b0;
    end

    // Power-good is armed one edge after reset release
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pg_arm_q <= 1'b0;
        else
            pg_arm_q <= 1'b1;
    end

    assign pll_pwrgood = pg_arm_q & ~tripped_q & ~trip_any;

endmodule

// File: rtl/hot_match.sv
module hot_match #(
    parameter int NCORE = 10,
    parameter int TW    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCORE*TW-1:0] core_temp,
    input  logic [TW-1:0]     fuse_trip,
    output logic              hot_q
);
    logic [NCORE-1:0] eq_vec;

    for (genvar gi = 0; gi < NCORE; gi++) begin : g_cmp
        assign eq_vec[gi] = (core_temp[gi*TW +: TW] == fuse_trip);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hot_q <= 1'b0;
        else
            hot_q <= |eq_vec;
    end

endmodule

// File: rtl/throttle_fsm.sv
module throttle_fsm
    import therm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hot,
    input  logic       force_thr_n,
    output logic       tm_req,
    output logic       min_ratio_req,
    output logic       thr_req,
    output logic [1:0] src_status
);
    logic       sync1_q;
    logic       sync2_q;
    logic       force_act;
    thr_state_t state_q;
    thr_state_t state_d;

    // Two-flop synchronizer, idle level is high (inactive)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b1;
            sync2_q <= 1'b1;
        end else begin
            sync1_q <= force_thr_n;
            sync2_q <= sync1_q;
        end
    end

    assign force_act = ~sync2_q;

    // Next state: every state goes straight to the one the sources name
    always_comb begin
        unique case ({force_act, hot})
            2'b00:   state_d = TS_RUN;
            2'b01:   state_d = TS_HOT;
            2'b10:   state_d = TS_FORCED;
            default: state_d = TS_BOTH;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= TS_RUN;
        else
            state_q <= state_d;
    end

    // Moore outputs
    always_comb begin
        unique case (state_q)
            TS_RUN: begin
                tm_req        = 1'b0;
                min_ratio_req = 1'b0;
            end
            TS_HOT: begin
                tm_req        = 1'b1;
                min_ratio_req = 1'b0;
            end
            TS_FORCED: begin
                tm_req        = 1'b0;
                min_ratio_req = 1'b1;
            end
            default: begin
                tm_req        = 1'b1;
                min_ratio_req = 1'b1;
            end
        endcase
        thr_req    = tm_req | min_ratio_req;
        src_status = {min_ratio_req, tm_req};
    end

endmodule

// File: rtl/clkmod_gen.sv
module clkmod_gen #(
    parameter int WIN_BITS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                thr_req,
    input  logic [WIN_BITS-1:0] duty_cfg,
    output logic                clkmod_en
);
    localparam logic [WIN_BITS-1:0] HALF_WIN = WIN_BITS'(1) << (WIN_BITS - 1);

    logic [WIN_BITS-1:0] phase_q;
    logic [WIN_BITS-1:0] eff_duty;

    assign eff_duty = (duty_cfg == '0) ? HALF_WIN : duty_cfg;

    // Window phase: held at zero when idle, wraps naturally at 2**WIN_BITS
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase_q <= '0;
        else if (thr_req)
            phase_q <= phase_q + WIN_BITS'(1);
        else
            phase_q <= '0;
    end

    assign clkmod_en = ~thr_req | (phase_q < eff_duty);

endmodule

// File: rtl/pkg_therm_ctrl.sv
module pkg_therm_ctrl
    import therm_pkg::*;
#(
    parameter int NCORE    = DEF_NCORE,
    parameter int TW       = DEF_TW,
    parameter int WIN_BITS = DEF_WIN_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCORE*TW-1:0] core_temp,
    input  logic [TW-1:0]       fuse_trip,
    input  logic [NCORE:0]      trip_flag,
    input  logic                force_thr_n,
    input  logic [WIN_BITS-1:0] duty_cfg,
    output logic                trip_n,
    output logic                pll_pwrgood,
    output logic                hot_n,
    output logic                tm_req,
    output logic                min_ratio_req,
    output logic                thr_req,
    output logic                clkmod_en,
    output logic [1:0]          src_status
);
    localparam int NSENS = NCORE + 1;

    logic hot_q;

    trip_guard #(.NSENS(NSENS)) u_trip (
        .clk         (clk),
        .rst_n       (rst_n),
        .trip_flag   (trip_flag),
        .trip_n      (trip_n),
        .pll_pwrgood (pll_pwrgood)
    );

    hot_match #(.NCORE(NCORE), .TW(TW)) u_hot (
        .clk       (clk),
        .rst_n     (rst_n),
        .core_temp (core_temp),
        .fuse_trip (fuse_trip),
        .hot_q     (hot_q)
    );

    assign hot_n = ~hot_q;

    throttle_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .hot           (hot_q),
        .force_thr_n   (force_thr_n),
        .tm_req        (tm_req),
        .min_ratio_req (min_ratio_req),
        .thr_req       (thr_req),
        .src_status    (src_status)
    );

    clkmod_gen #(.WIN_BITS(WIN_BITS)) u_mod (
        .clk       (clk),
        .rst_n     (rst_n),
        .thr_req   (thr_req),
        .duty_cfg  (duty_cfg),
        .clkmod_en (clkmod_en)
    );

endmodule

// File: rtl/therm_ctrl_chk.sv
module therm_ctrl_chk #(
    parameter int NCORE = 10,
    parameter int TW    = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NCORE*TW-1:0] core_temp,
    input logic [TW-1:0]       fuse_trip,
    input logic [NCORE:0]      trip_flag,
    input logic                force_thr_n,
    input logic                pll_pwrgood,
    input logic                hot_n,
    input logic                tm_req,
    input logic                min_ratio_req,
    input logic                thr_req,
    input logic                clkmod_en
);
    logic any_eq;

    always_comb begin
        any_eq = 1'b0;
        for (int i = 0; i < NCORE; i++)
            if (core_temp[i*TW +: TW] == fuse_trip) any_eq = 1'b1;
    end

    AST_TRIP_KILLS_PG: assert property (@(posedge clk) disable iff (!rst_n)
        (|trip_flag) |-> !pll_pwrgood); // R2

    AST_PG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !pll_pwrgood) |=> !pll_pwrgood); // R3

    AST_HOT_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        any_eq |=> !hot_n); // R4

    AST_TM_AFTER_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        tm_req |-> $past(!hot_n)); // R6

    AST_FORCE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        min_ratio_req |-> !$past(force_thr_n, 3)); // R7

    AST_CLK_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !thr_req |-> clkmod_en); // R9

    AST_WINDOW_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(thr_req) |-> clkmod_en); // R10

endmodule

bind pkg_therm_ctrl therm_ctrl_chk #(.NCORE(NCORE), .TW(TW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .core_temp     (core_temp),
    .fuse_trip     (fuse_trip),
    .trip_flag     (trip_flag),
    .force_thr_n   (force_thr_n),
    .pll_pwrgood   (pll_pwrgood),
    .hot_n         (hot_n),
    .tm_req        (tm_req),
    .min_ratio_req (min_ratio_req),
    .thr_req       (thr_req),
    .clkmod_en     (clkmod_en)
);

// File: tb/tb_pkg_therm_ctrl.sv
`timescale 1ns/1ps
module tb_pkg_therm_ctrl;
    localparam int NCORE = 10;
    localparam int TW    = 8;
    localparam int WB    = 4;
    localparam int WIN   = 1 << WB;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NCORE*TW-1:0] core_temp = '0;
    logic [TW-1:0]       fuse_trip = 8'd100;
    logic [NCORE:0]      trip_flag = '0;
    logic                force_thr_n = 1'b1;
    logic [WB-1:0]       duty_cfg = '0;
    logic trip_n, pll_pwrgood, hot_n, tm_req, min_ratio_req, thr_req, clkmod_en;
    logic [1:0] src_status;

    int total = 0;
    int bad   = 0;

    // bench model state
    logic m_hot = 0, m_s1 = 1, m_s2 = 1, m_tm = 0, m_min = 0, m_arm = 0, m_tripped = 0;
    int   m_phase = 0;

    always #4 clk = ~clk;

    pkg_therm_ctrl #(.NCORE(NCORE), .TW(TW), .WIN_BITS(WB)) dut (
        .clk(clk), .rst_n(rst_n), .core_temp(core_temp), .fuse_trip(fuse_trip),
        .trip_flag(trip_flag), .force_thr_n(force_thr_n), .duty_cfg(duty_cfg),
        .trip_n(trip_n), .pll_pwrgood(pll_pwrgood), .hot_n(hot_n), .tm_req(tm_req),
        .min_ratio_req(min_ratio_req), .thr_req(thr_req), .clkmod_en(clkmod_en),
        .src_status(src_status)
    );

    function automatic logic match_any(logic [NCORE*TW-1:0] t, logic [TW-1:0] f);
        for (int i = 0; i < NCORE; i++)
            if (t[i*TW +: TW] == f) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int eff_duty(logic [WB-1:0] d);
        return (d == 0) ? WIN / 2 : int'(d);
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d time=%0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        logic thr;
        thr = m_tm | m_min;
        if (|trip_flag) m_tripped = 1'b1;
        chk("R1 trip_n", trip_n, !(|trip_flag));
        chk("R3 pll_pwrgood", pll_pwrgood, m_arm & ~m_tripped & ~(|trip_flag));
        chk("R4 hot_n", hot_n, !m_hot);
        chk("R6 tm_req", tm_req, m_tm);
        chk("R7 min_ratio_req", min_ratio_req, m_min);
        chk("R8 thr_req", thr_req, thr);
        chk("R8 src_status", src_status, {m_min, m_tm});
        chk("R9 clkmod_en", clkmod_en, !thr || (m_phase < eff_duty(duty_cfg)));
    endtask

    // one clock: model update at the edge, compare at the following falling edge
    task automatic tick();
        logic nh, old_thr;
        @(posedge clk);
        nh = match_any(core_temp, fuse_trip);
        old_thr = m_tm | m_min;
        if (!rst_n) begin
            m_hot = 0; m_s1 = 1; m_s2 = 1; m_tm = 0; m_min = 0; m_phase = 0; m_arm = 0;
            if (trip_flag == 0) m_tripped = 0;
        end else begin
            m_tm = m_hot;
            m_min = ~m_s2;
            m_phase = old_thr ? (m_phase + 1) % WIN : 0;
            m_s2 = m_s1;
            m_s1 = force_thr_n;
            m_hot = nh;
            m_arm = 1;
        end
        if (|trip_flag) m_tripped = 1'b1;
        @(negedge clk);
        check_all();
    endtask

    task automatic set_all_cores(logic [TW-1:0] v);
        for (int i = 0; i < NCORE; i++) core_temp[i*TW +: TW] = v;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog R11 actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int en_cnt;
        void'($urandom(32'h5eed_0bad));
        set_all_cores(8'd50);
        force_thr_n = 1'b0;          // must be ignored under reset
        repeat (3) tick();
        // R11 reset state
        chk("R11 hot_n", hot_n, 1);
        chk("R11 thr_req", thr_req, 0);
        chk("R11 min_ratio_req", min_ratio_req, 0);
        chk("R11 src_status", src_status, 0);
        chk("R11 clkmod_en", clkmod_en, 1);
        chk("R11 pll_pwrgood", pll_pwrgood, 0);
        force_thr_n = 1'b1;
        rst_n = 1'b1;
        tick();
        chk("R3 pwrgood after reset", pll_pwrgood, 1);

        // R4 near misses do not match
        fuse_trip = 8'd90;
        core_temp[2*TW +: TW] = 8'd89;
        core_temp[5*TW +: TW] = 8'd91;
        repeat (3) tick();
        chk("R4 off-by-one ignored", hot_n, 1);
        core_temp[7*TW +: TW] = 8'd90;
        tick();
        chk("R4 exact match", hot_n, 0);
        chk("R6 tm not yet", tm_req, 0);
        tick();
        chk("R6 tm one edge later", tm_req, 1);
        repeat (4) tick();
        chk("R5 hold while matching", hot_n, 0);
        core_temp[7*TW +: TW] = 8'd88;
        tick();
        chk("R5 release", hot_n, 1);
        repeat (20) tick();

        // R7 synchronizer latency, R10 zero duty means half
        duty_cfg = '0;
        force_thr_n = 1'b0;
        tick(); tick();
        chk("R7 not after two edges", min_ratio_req, 0);
        tick();
        chk("R7 after third edge", min_ratio_req, 1);
        chk("R8 forced source bit", src_status, 2);
        en_cnt = 0;
        for (int k = 0; k < WIN; k++) begin
            if (clkmod_en) en_cnt++;
            tick();
        end
        chk("R10 zero duty gives half", en_cnt, WIN / 2);
        duty_cfg = 4'd3;
        en_cnt = 0;
        for (int k = 0; k < WIN; k++) begin
            if (clkmod_en) en_cnt++;
            tick();
        end
        chk("R9 duty three of sixteen", en_cnt, 3);
        force_thr_n = 1'b1;
        repeat (5) tick();
        chk("R9 free running when idle", clkmod_en, 1);

        // R1 R2 R3 trip path between edges
        trip_flag[NCORE] = 1'b1;     // uncore sensor
        #1;
        chk("R1 uncore trip immediate", trip_n, 0);
        chk("R2 pwrgood drops immediately", pll_pwrgood, 0);
        m_tripped = 1'b1;
        tick(); tick();
        trip_flag = '0;
        repeat (6) tick();
        chk("R3 pwrgood stays low", pll_pwrgood, 0);
        chk("R1 trip released", trip_n, 1);
        rst_n = 1'b0;
        repeat (2) tick();
        rst_n = 1'b1;
        tick();
        chk("R3 pwrgood back after reset", pll_pwrgood, 1);
        trip_flag[3] = 1'b1;
        #1;
        chk("R1 core trip immediate", trip_n, 0);
        chk("R2 core trip kills pwrgood", pll_pwrgood, 0);
        m_tripped = 1'b1;
        tick();
        trip_flag = '0;
        rst_n = 1'b0;
        repeat (2) tick();
        rst_n = 1'b1;
        tick();

        // constrained random mix
        for (int c = 0; c < 6000; c++) begin
            if (c % 400 == 0) fuse_trip = 8'($urandom_range(40, 120));
            if (c % 200 == 0) duty_cfg = WB'($urandom);
            for (int i = 0; i < NCORE; i++) begin
                int r = $urandom % 64;
                if (r == 0)      core_temp[i*TW +: TW] = fuse_trip;
                else if (r < 20) core_temp[i*TW +: TW] = fuse_trip + 8'd1;
                else if (r < 40) core_temp[i*TW +: TW] = fuse_trip - 8'd1;
                else             core_temp[i*TW +: TW] = 8'($urandom_range(20, 35));
            end
            if ($urandom % 24 == 0) force_thr_n = ~force_thr_n;
            tick();
        end

        summary();
        $finish;
    end
endmodule